// File: doc/BRIEF.md
# Dual-Format Serial Audio Receiver

This block turns a three-wire serial audio stream into parallel stereo samples. The three wires are a bit clock, a frame clock and one data line. The block runs entirely in the bit-clock domain and samples both the frame clock and the data line on each rising edge of the bit clock. Each sample is 16 bits wide. A frame clock period carries one left sample and one right sample.

A static format input chooses between two word alignments:

- **Right-justified, MSB first.** The frame clock is high for the left channel. The word is the last 16 bits that arrive before the frame clock changes level.
- **I2S.** The frame clock is low for the left channel. The word starts one bit clock after the frame clock changes level.

When the right word of a frame completes, the block publishes the left and right words together and raises a strobe for one bit clock. A change on the format input takes effect only at the next frame start. A frame that is in progress therefore finishes in its old format. A pair of words is published only when a left word completed before the right word under the current format, so no frame with mixed content is ever emitted.

Top module: `serial_audio_rx`

## Requirements
- R1: While `rst_n` is low at a rising bit-clock edge, the following hold:
  - `left_word` and `right_word` clear to 0.
  - `word_valid` goes low.
  - The present level of the frame clock is taken as the current level, so the first edge after reset does not see a spurious transition.
  - The present value of the format input is taken as the active format.
- R2: With `fmt_i2s` = 1 (I2S), the channel and bit positions are as follows:
  - A low frame clock marks the left slot and a high frame clock marks the right slot.
  - The first rising bit-clock edge that sees the new frame level carries the last bit of the previous slot.
  - The MSB of the slot's word is sampled on the second rising edge after the transition.
  - The remaining 15 bits follow MSB first on the 15 rising edges after that.
- R3: In I2S mode, any bits that a slot carries beyond its 16th word bit are ignored and leave the captured word unchanged.
- R4: With `fmt_i2s` = 0 (right-justified), the channel and bit positions are as follows:
  - A high frame clock marks the left slot and a low frame clock marks the right slot.
  - The word is made of the 16 bits sampled on the 16 rising edges just before the edge that sees the frame transition.
  - The LSB is the last of those bits.
- R5: In right-justified mode, any leading bits of a slot longer than 16 bit clocks are discarded.
- R6: `word_valid` is high for exactly one bit-clock cycle, and the timing depends on the format:
  - In right-justified mode it rises after the rising edge that sees the transition ending the right slot.
  - In I2S mode it rises after the rising edge that samples the right word's 16th bit.
- R7: `left_word` and `right_word` change only together with a rise of `word_valid`. A pair is published only when a left word has completed since the last publication, reset or format switch.
- R8: A new value on `fmt_i2s` becomes active at the next frame-clock transition into the left level of the format that is active at that moment. A frame that is in progress when the input changes is decoded in its old format, and no partial frame is published across the switch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Serial bit clock; all sampling on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_clk | input | 1 | Frame clock; its level selects the channel slot |
| ser_data | input | 1 | Serial sample data |
| fmt_i2s | input | 1 | Format select: 1 = I2S, 0 = right-justified MSB first |
| left_word | output | 16 | Left sample of the last published frame |
| right_word | output | 16 | Right sample of the last published frame |
| word_valid | output | 1 | One-cycle strobe when a new left/right pair is published |

## Verification
The hardest situation to reach from the ports is a format switch in the middle of a stream. The stimulus must change the format input inside a frame and then check three things:

- the in-flight frame still decodes in the old format;
- the slot that straddles the switch produces no output;
- the next full frame decodes in the new format.

The bench drives an I2S frame, flips the format input during that frame's left slot, and then streams a right-justified frame. It checks that exactly two pairs are published, each with the intended values. Slot lengths of 16, 17, 20, 24 and 32 bit clocks are used. They place the frame transition exactly on, or well past, the 16th bit, which exercises the one-bit delay and the discarded bits in both formats.

// File: rtl/serial_audio_rx.sv
module serial_audio_rx #(
  parameter int SAMPLE_W = 16
) (
  input  logic                bit_clk,
  input  logic                rst_n,
  input  logic                frame_clk,
  input  logic                ser_data,
  input  logic                fmt_i2s,
  output logic [SAMPLE_W-1:0] left_word,
  output logic [SAMPLE_W-1:0] right_word,
  output logic                word_valid
);
  localparam int CNT_W = $clog2(SAMPLE_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(SAMPLE_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SAMPLE_W - 1);

  logic                frame_q, fmt_act, slot_right, primed;
  logic [CNT_W-1:0]    cnt;
  logic [SAMPLE_W-1:0] shreg, left_hold, word_cap;
  logic                frame_edge, frame_start, take_bit, word_done;

  assign frame_edge  = frame_clk ^ frame_q;
  assign frame_start = frame_edge && (frame_clk == ~fmt_act);
  assign take_bit    = fmt_act ? (cnt != FULL) : 1'b1;
  assign word_done   = fmt_act ? (cnt == LAST) : frame_edge;
  assign word_cap    = fmt_act ? {shreg[SAMPLE_W-2:0], ser_data} : shreg;

  always_ff @(posedge bit_clk) begin
    if (!rst_n) begin
      frame_q    <= frame_clk;
      fmt_act    <= fmt_i2s;
      slot_right <= 1'b1;
      primed     <= 1'b0;
      cnt        <= FULL;
      shreg      <= '0;
      left_hold  <= '0;
      left_word  <= '0;
      right_word <= '0;
      word_valid <= 1'b0;
    end else begin
      frame_q    <= frame_clk;
      word_valid <= 1'b0;
      if (take_bit) shreg <= {shreg[SAMPLE_W-2:0], ser_data};
      if (word_done) begin
        if (!slot_right) begin
          left_hold <= word_cap;
          primed    <= 1'b1;
        end else if (primed) begin
          left_word  <= left_hold;
          right_word <= word_cap;
          word_valid <= 1'b1;
          primed     <= 1'b0;
        end
      end
      if (frame_edge) begin
        cnt <= '0;
        if (frame_start) begin
          fmt_act    <= fmt_i2s;
          slot_right <= 1'b0;
          primed     <= 1'b0;
        end else begin
          slot_right <= fmt_act ? frame_clk : ~frame_clk;
        end
      end else if (fmt_act && take_bit) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R6: strobe lasts one bit clock
  a_r6_single_strobe: assert property (@(posedge bit_clk) disable iff (!rst_n)
    word_valid |=> !word_valid);

  // R7: outputs move only with the strobe
  a_r7_hold_outputs: assert property (@(posedge bit_clk) disable iff (!rst_n)
    !word_valid |-> ($stable(left_word) && $stable(right_word)));

  // R7: a publication follows a right-slot completion
  a_r7_right_slot: assert property (@(posedge bit_clk) disable iff (!rst_n)
    word_valid |-> $past(slot_right));

  // R3: a full I2S word ignores further bits until the next edge
  a_r3_i2s_ignore: assert property (@(posedge bit_clk) disable iff (!rst_n)
    (fmt_act && cnt == FULL && !frame_edge) |=> $stable(shreg));

  // R8: format only switches at a frame transition
  a_r8_fmt_at_edge: assert property (@(posedge bit_clk) disable iff (!rst_n)
    !frame_edge |=> $stable(fmt_act));
endmodule

// File: tb/serial_audio_rx_tb.sv
`timescale 1ns/1ps
module serial_audio_rx_tb_top;
  logic clk = 0, rst_n = 0, frame = 0, sdata = 0, fmt = 0;
  logic [15:0] lw, rw;
  logic vld;

  always #2.5 clk = ~clk;

  serial_audio_rx dut_i (
    .bit_clk(clk), .rst_n(rst_n), .frame_clk(frame), .ser_data(sdata),
    .fmt_i2s(fmt), .left_word(lw), .right_word(rw), .word_valid(vld));

  // {fmt, slot length, left, right}
  localparam logic [38:0] VECS [7] = '{
    {1'b1, 6'd16, 16'hA5C3, 16'h3C5A},
    {1'b1, 6'd32, 16'h8001, 16'h7FFE},
    {1'b1, 6'd24, 16'h0000, 16'hFFFF},
    {1'b1, 6'd17, 16'h0001, 16'h8000},
    {1'b0, 6'd16, 16'h1234, 16'hABCD},
    {1'b0, 6'd32, 16'h8000, 16'h0001},
    {1'b0, 6'd20, 16'h0FF0, 16'hF00F}
  };

  int nchk = 0, nfail = 0;
  int cyc = 0, nval = 0, dbl = 0, vcyc = 0, last_start = 0;
  logic lastv = 0;
  logic [15:0] gl [4];
  logic [15:0] gr [4];
  bit tb_fmt = 0;
  logic [15:0] prev_w = 0;
  int prev_n = 17;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n && vld) begin
      if (lastv) dbl++;
      if (nval < 4) begin gl[nval] = lw; gr[nval] = rw; end
      vcyc = cyc;
      nval++;
    end
    lastv = rst_n && vld;
  end

  task automatic chk(string tag, string what, int got, int exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic do_reset(bit f);
    @(negedge clk);
    rst_n = 0; fmt = f; tb_fmt = f; frame = f; sdata = 0;
    repeat (3) @(negedge clk);
    chk("R1", "left after reset", lw, 0);
    chk("R1", "right after reset", rw, 0);
    chk("R1", "valid after reset", vld, 0);
    rst_n = 1; nval = 0; dbl = 0; prev_w = 0; prev_n = 17;
  endtask

  task automatic slot(bit lvl, logic [15:0] w, int n);
    for (int i = 0; i < n; i++) begin
      int p;
      logic [15:0] src;
      @(negedge clk);
      if (i == 0) last_start = cyc;
      frame = lvl;
      if (tb_fmt) begin
        if (i == 0) begin p = prev_n - 1; src = prev_w; end
        else begin p = i - 1; src = w; end
        sdata = (p < 16) ? src[15-p] : 1'b1;
      end else begin
        sdata = (i >= n - 16) ? w[n-1-i] : 1'b1;
      end
    end
    prev_w = w; prev_n = n;
  endtask

  task automatic run_vec(bit f, int n, logic [15:0] l, logic [15:0] r);
    bit ll;
    int rs, ts;
    string tag;
    ll = f ? 1'b0 : 1'b1;
    tag = f ? ((n > 16) ? "R3" : "R2") : ((n > 16) ? "R5" : "R4");
    do_reset(f);
    slot(ll, l, n);
    slot(~ll, r, n);
    rs = last_start;
    slot(ll, 16'h0000, n);
    ts = last_start;
    repeat (3) @(negedge clk);
    chk(tag, "frames published", nval, 1);
    chk(tag, "left word", gl[0], l);
    chk(tag, "right word", gr[0], r);
    chk("R6", "strobe cycle", vcyc, f ? rs + 17 : ts + 1);
    chk("R6", "strobe width", dbl, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
      $finish;
    end
  end

  initial begin
    foreach (VECS[k])
      run_vec(VECS[k][38], int'(VECS[k][37:32]), VECS[k][31:16], VECS[k][15:0]);

    // R7: outputs hold until the whole next pair is ready
    do_reset(1'b0);
    slot(1'b1, 16'h1111, 16);
    slot(1'b0, 16'h2222, 16);
    slot(1'b1, 16'h3333, 16);
    slot(1'b0, 16'h4444, 16);
    chk("R7", "left held mid-frame", lw, 16'h1111);
    chk("R7", "right held mid-frame", rw, 16'h2222);
    slot(1'b1, 16'h0000, 16);
    repeat (3) @(negedge clk);
    chk("R7", "frames published", nval, 2);
    chk("R7", "second left", gl[1], 16'h3333);
    chk("R7", "second right", gr[1], 16'h4444);

    // R8: format flipped inside an I2S frame
    do_reset(1'b1);
    slot(1'b0, 16'hAAAA, 16);
    fmt = 0;
    slot(1'b1, 16'hBBBB, 16);
    slot(1'b0, 16'h5A5A, 16);
    tb_fmt = 0;
    slot(1'b1, 16'hCCCC, 16);
    slot(1'b0, 16'hDDDD, 16);
    slot(1'b1, 16'h0000, 16);
    repeat (3) @(negedge clk);
    chk("R8", "frames published", nval, 2);
    chk("R8", "old-format left", gl[0], 16'hAAAA);
    chk("R8", "old-format right", gr[0], 16'hBBBB);
    chk("R8", "new-format left", gl[1], 16'hCCCC);
    chk("R8", "new-format right", gr[1], 16'hDDDD);
    chk("R6", "strobe width", dbl, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end
endmodule